// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the register state of a small processor core. Sixteen live general registers are what the core sees in its current mode. Per-bank shadow storage keeps copies of selected upper registers for the other modes. A mode change request carries a 5-bit mode code. The block resolves the old and new codes to bank indices. When the banks differ, it moves the affected registers between the live set and the shadow storage in the same clock that latches the new mode.

A side port reads and writes a register as seen from any mode code. An access that names the current mode code reaches the live set. An access that names another code reaches that code's bank storage for r8 to r14; all other registers are never banked and always reach the live set. Every bank except user and system also keeps a saved status word, reached through a second side port. A non-translated access flag follows the low bits of the current mode.

Top module: `banked_regfile`

## Requirements
- R1: The mode-to-bank map is: codes 0/16 user, 1/17 fast-interrupt, 2/18 interrupt, 3/19 supervisor, 23 abort, 27 undefined, 31 system, and every other code a dummy bank.
- R2: A mode change whose old and new codes resolve to the same bank leaves the live set and the shadow storage unchanged.
- R3: On leaving a user-style bank (any bank other than fast-interrupt and dummy), live r13 and r14 go into the old bank's storage, and live r8 to r12 also go into the user bank's storage when the new bank is fast-interrupt. On entering a user-style bank, r13 and r14 come from the new bank's storage, and r8 to r12 come from the user bank's storage when the old bank is fast-interrupt.
- R4: On leaving the fast-interrupt bank, live r8 to r14 go into its storage. On entering it, live r8 to r14 are loaded from that storage.
- R5: On leaving the dummy bank, its stored r8 to r14 are cleared. On entering it, live r8 to r14 become zero.
- R6: A side-port access whose mode code equals the current code, or whose index is outside r8 to r14 (index 0 to 7 or 15), uses the live register. Any other access uses the r8 to r14 slot of the named code's bank. Reads are combinational and writes take effect at the next clock edge.
- R7: A register write requested in the same cycle as a mode change is dropped.
- R8: Each bank other than user and system keeps one saved status word. A read naming a user or system code returns the `cur_status` input, and a write naming such a code changes nothing.
- R9: `nontrans` is high exactly when the two low bits of the current mode code are not both zero.
- R10: Reset selects mode code 19 (supervisor) and clears the live set, all shadow storage and all saved status words.
- R11: A mode change is complete at the clock edge that samples the request: `cur_mode` shows the new code in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chg | input | 1 | Request a mode change this cycle |
| mode_new | input | 5 | Mode code to switch to |
| cur_mode | output | 5 | Current mode code |
| nontrans | output | 1 | Non-translated access flag |
| rd_mode | input | 5 | Mode code the register read is seen from |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | DATA_W | Read data (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_mode | input | 5 | Mode code the register write is seen from |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | DATA_W | Register write data |
| cur_status | input | DATA_W | Current status word from the core |
| st_rd_mode | input | 5 | Mode code whose saved status is read |
| st_rd_data | output | DATA_W | Saved status read data (combinational) |
| st_wr_en | input | 1 | Saved status write enable |
| st_wr_mode | input | 5 | Mode code whose saved status is written |
| st_wr_data | input | DATA_W | Saved status write data |

## Verification
A wrong swap rule leaves a stale or lost value in r8 to r14. It shows at the read port in the cycle right after the mode change when read from the current mode. It also shows when the bank it should have gone to is read from another mode code. A wrong mode map shows as a swap where none is due, or a missing one, and it shows in the saved status reads of the affected codes straight away. The comparison model therefore scans every live register, two shadow slots of each bank and every saved status word after each clock. A fault cannot hide for longer than one cycle once its value is visible.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int MODE_W       = 5;
    localparam int NUM_REGS     = 16;
    localparam int IDX_W        = $clog2(NUM_REGS);
    localparam int SHADOW_LO    = 8;
    localparam int SHADOW_CNT   = 7;
    localparam int FIQ_ONLY_CNT = 5;
    localparam int NUM_BANKS    = 8;
    localparam int SLOT_CNT     = NUM_BANKS * SHADOW_CNT;
    localparam int SLOT_W       = $clog2(SLOT_CNT);
    localparam int BANK_W       = $clog2(NUM_BANKS);

    typedef enum logic [BANK_W-1:0] {
        BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_DUM
    } bank_e;

    localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;
    localparam int FIQ_BASE = int'(BK_FIQ) * SHADOW_CNT;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            5'd0,  5'd16: return BK_USR;
            5'd1,  5'd17: return BK_FIQ;
            5'd2,  5'd18: return BK_IRQ;
            5'd3,  5'd19: return BK_SVC;
            5'd23:        return BK_ABT;
            5'd27:        return BK_UND;
            5'd31:        return BK_SYS;
            default:      return BK_DUM;
        endcase
    endfunction

    function automatic logic keeps_status(input bank_e b);
        return !(b == BK_USR || b == BK_SYS);
    endfunction

    function automatic logic in_shadow(input logic [IDX_W-1:0] i);
        return (int'(i) >= SHADOW_LO) && (int'(i) < SHADOW_LO + SHADOW_CNT);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input bank_e b, input logic [IDX_W-1:0] i);
        return SLOT_W'(int'(b) * SHADOW_CNT + int'(i) - SHADOW_LO);
    endfunction

endpackage

// File: rtl/rf_word_array.sv
module rf_word_array #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEPTH-1:0]          we,
    input  logic [DEPTH-1:0][W-1:0]   wd,
    output logic [DEPTH-1:0][W-1:0]   q
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)        q[k] <= '0;
            else if (we[k]) q[k] <= wd[k];
        end
    end
endmodule

// File: rtl/rf_swap_ctrl.sv
module rf_swap_ctrl
    import rf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [MODE_W-1:0]               cur_mode,
    input  logic                            mode_chg,
    input  logic [MODE_W-1:0]               mode_new,
    input  logic                            wr_en,
    input  logic [MODE_W-1:0]               wr_mode,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [W-1:0]                    wr_data,
    input  logic [NUM_REGS-1:0][W-1:0]      live_q,
    input  logic [SLOT_CNT-1:0][W-1:0]      shadow_q,
    output logic [NUM_REGS-1:0]             live_we,
    output logic [NUM_REGS-1:0][W-1:0]      live_wd,
    output logic [SLOT_CNT-1:0]             shadow_we,
    output logic [SLOT_CNT-1:0][W-1:0]      shadow_wd
);
    bank_e old_b, new_b;

    always_comb begin
        old_b     = bank_of(cur_mode);
        new_b     = bank_of(mode_new);
        live_we   = '0;
        live_wd   = live_q;
        shadow_we = '0;
        shadow_wd = shadow_q;

        if (mode_chg) begin
            if (old_b != new_b) begin
                // save side
                case (old_b)
                    BK_FIQ: begin
                        for (int s = 0; s < SHADOW_CNT; s++) begin
                            shadow_we[FIQ_BASE + s] = 1'b1;
                            shadow_wd[FIQ_BASE + s] = live_q[SHADOW_LO + s];
                        end
                    end
                    BK_DUM: begin
                        for (int s = 0; s < SHADOW_CNT; s++) begin
                            shadow_we[int'(BK_DUM) * SHADOW_CNT + s] = 1'b1;
                            shadow_wd[int'(BK_DUM) * SHADOW_CNT + s] = '0;
                        end
                    end
                    default: begin
                        if (new_b == BK_FIQ) begin
                            for (int s = 0; s < FIQ_ONLY_CNT; s++) begin
                                shadow_we[int'(BK_USR) * SHADOW_CNT + s] = 1'b1;
                                shadow_wd[int'(BK_USR) * SHADOW_CNT + s] = live_q[SHADOW_LO + s];
                            end
                        end
                        for (int s = FIQ_ONLY_CNT; s < SHADOW_CNT; s++) begin
                            shadow_we[int'(old_b) * SHADOW_CNT + s] = 1'b1;
                            shadow_wd[int'(old_b) * SHADOW_CNT + s] = live_q[SHADOW_LO + s];
                        end
                    end
                endcase
                // restore side
                case (new_b)
                    BK_FIQ: begin
                        for (int s = 0; s < SHADOW_CNT; s++) begin
                            live_we[SHADOW_LO + s] = 1'b1;
                            live_wd[SHADOW_LO + s] = shadow_q[FIQ_BASE + s];
                        end
                    end
                    BK_DUM: begin
                        for (int s = 0; s < SHADOW_CNT; s++) begin
                            live_we[SHADOW_LO + s] = 1'b1;
                            live_wd[SHADOW_LO + s] = '0;
                        end
                    end
                    default: begin
                        if (old_b == BK_FIQ) begin
                            for (int s = 0; s < FIQ_ONLY_CNT; s++) begin
                                live_we[SHADOW_LO + s] = 1'b1;
                                live_wd[SHADOW_LO + s] = shadow_q[int'(BK_USR) * SHADOW_CNT + s];
                            end
                        end
                        for (int s = FIQ_ONLY_CNT; s < SHADOW_CNT; s++) begin
                            live_we[SHADOW_LO + s] = 1'b1;
                            live_wd[SHADOW_LO + s] = shadow_q[int'(new_b) * SHADOW_CNT + s];
                        end
                    end
                endcase
            end
        end else if (wr_en) begin
            if (wr_mode == cur_mode || !in_shadow(wr_idx)) begin
                live_we[wr_idx] = 1'b1;
                live_wd[wr_idx] = wr_data;
            end else begin
                shadow_we[slot_of(bank_of(wr_mode), wr_idx)] = 1'b1;
                shadow_wd[slot_of(bank_of(wr_mode), wr_idx)] = wr_data;
            end
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_chg,
    input  logic [4:0]        mode_new,
    output logic [4:0]        cur_mode,
    output logic              nontrans,
    input  logic [4:0]        rd_mode,
    input  logic [3:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_mode,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cur_status,
    input  logic [4:0]        st_rd_mode,
    output logic [DATA_W-1:0] st_rd_data,
    input  logic              st_wr_en,
    input  logic [4:0]        st_wr_mode,
    input  logic [DATA_W-1:0] st_wr_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0]  live_q, live_wd;
    logic [NUM_REGS-1:0]              live_we;
    logic [SLOT_CNT-1:0][DATA_W-1:0]  shadow_q, shadow_wd;
    logic [SLOT_CNT-1:0]              shadow_we;
    logic [NUM_BANKS-1:0][DATA_W-1:0] status_q, status_wd;
    logic [NUM_BANKS-1:0]             status_we;
    logic [MODE_W-1:0]                mode_q;
    bank_e                            st_rd_b, st_wr_b;

    always_ff @(posedge clk) begin
        if (rst)           mode_q <= RESET_MODE;
        else if (mode_chg) mode_q <= mode_new;
    end

    assign cur_mode = mode_q;
    assign nontrans = |mode_q[1:0];

    rf_swap_ctrl #(.W(DATA_W)) swap_i (
        .cur_mode (mode_q),
        .mode_chg (mode_chg),
        .mode_new (mode_new),
        .wr_en    (wr_en),
        .wr_mode  (wr_mode),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .live_q   (live_q),
        .shadow_q (shadow_q),
        .live_we  (live_we),
        .live_wd  (live_wd),
        .shadow_we(shadow_we),
        .shadow_wd(shadow_wd)
    );

    rf_word_array #(.W(DATA_W), .DEPTH(NUM_REGS)) live_i (
        .clk(clk), .rst(rst), .we(live_we), .wd(live_wd), .q(live_q)
    );

    rf_word_array #(.W(DATA_W), .DEPTH(SLOT_CNT)) shadow_i (
        .clk(clk), .rst(rst), .we(shadow_we), .wd(shadow_wd), .q(shadow_q)
    );

    always_comb begin
        st_wr_b   = bank_of(st_wr_mode);
        status_we = '0;
        status_wd = status_q;
        if (st_wr_en && keeps_status(st_wr_b)) begin
            status_we[st_wr_b] = 1'b1;
            status_wd[st_wr_b] = st_wr_data;
        end
    end

    rf_word_array #(.W(DATA_W), .DEPTH(NUM_BANKS)) status_i (
        .clk(clk), .rst(rst), .we(status_we), .wd(status_wd), .q(status_q)
    );

    always_comb begin
        st_rd_b = bank_of(st_rd_mode);
        st_rd_data = keeps_status(st_rd_b) ? status_q[st_rd_b] : cur_status;
        if (rd_mode == mode_q || !in_shadow(rd_idx))
            rd_data = live_q[rd_idx];
        else
            rd_data = shadow_q[slot_of(bank_of(rd_mode), rd_idx)];
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            mode_chg,
    input logic [4:0]                      mode_new,
    input logic [4:0]                      cur_mode,
    input logic                            nontrans,
    input logic [DATA_W-1:0]               cur_status,
    input logic [4:0]                      st_rd_mode,
    input logic [DATA_W-1:0]               st_rd_data,
    input logic [NUM_REGS-1:0][DATA_W-1:0] live_q,
    input logic [SLOT_CNT-1:0][DATA_W-1:0] shadow_q
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_mode == RESET_MODE && live_q == '0 && shadow_q == '0)); // R10

    AST_MODE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (cur_mode == $past(mode_new))); // R11

    AST_NONTRANS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (nontrans == ($past(mode_new[1:0]) != 2'b00))); // R9

    AST_SAME_BANK_STILL: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && bank_of(cur_mode) == bank_of(mode_new))
        |=> ($stable(live_q) && $stable(shadow_q))); // R2

    AST_DUMMY_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && bank_of(mode_new) == BK_DUM && bank_of(cur_mode) != BK_DUM)
        |=> (live_q[SHADOW_LO+SHADOW_CNT-1:SHADOW_LO] == '0)); // R5

    AST_FIQ_LOAD: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && bank_of(mode_new) == BK_FIQ && bank_of(cur_mode) != BK_FIQ)
        |=> (live_q[SHADOW_LO+SHADOW_CNT-1:SHADOW_LO]
             == $past(shadow_q[FIQ_BASE+SHADOW_CNT-1:FIQ_BASE]))); // R4

    AST_STATUS_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        !keeps_status(bank_of(st_rd_mode)) |-> (st_rd_data == cur_status)); // R8
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mode_chg  (mode_chg),
    .mode_new  (mode_new),
    .cur_mode  (cur_mode),
    .nontrans  (nontrans),
    .cur_status(cur_status),
    .st_rd_mode(st_rd_mode),
    .st_rd_data(st_rd_data),
    .live_q    (live_q),
    .shadow_q  (shadow_q)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/10ps
module banked_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_chg = 1'b0;
    logic [4:0]  mode_new = '0;
    logic [4:0]  cur_mode;
    logic        nontrans;
    logic [4:0]  rd_mode = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_mode = '0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_status = 32'h600D_0000;
    logic [4:0]  st_rd_mode = '0;
    logic [31:0] st_rd_data;
    logic        st_wr_en = 1'b0;
    logic [4:0]  st_wr_mode = '0;
    logic [31:0] st_wr_data = '0;

    always #2.5 clk = ~clk;

    banked_regfile dut_i (.*);

    // behavioural reference model
    logic [31:0] m_live [0:15];
    logic [31:0] m_sh   [0:7][0:15];
    logic [31:0] m_st   [0:7];
    logic [4:0]  m_mode;
    int          n_chk = 0;
    int          n_err = 0;
    string       phase = "R10 reset";
    int          probe_modes [8] = '{16, 17, 18, 19, 23, 27, 31, 5};

    function automatic int mbank(input logic [4:0] m);
        if (m == 5'd23) return 4;
        if (m == 5'd27) return 5;
        if (m == 5'd31) return 6;
        if (m[3:2] == 2'b00 && m[4:2] != 3'b010 && m[4:2] != 3'b110) return int'(m[1:0]);
        return 7;
    endfunction

    function automatic bit uses_live(input logic [4:0] m, input int i);
        return (m == m_mode) || i < 8 || i == 15;
    endfunction

    task automatic model_reset();
        m_mode = 5'd19;
        for (int i = 0; i < 16; i++) m_live[i] = '0;
        for (int b = 0; b < 8; b++) begin
            m_st[b] = '0;
            for (int i = 0; i < 16; i++) m_sh[b][i] = '0;
        end
    endtask

    task automatic model_switch(input logic [4:0] nm);
        int ob = mbank(m_mode);
        int nb = mbank(nm);
        if (ob != nb) begin
            if (ob == 1) begin
                for (int r = 8; r <= 14; r++) m_sh[1][r] = m_live[r];
            end else if (ob == 7) begin
                for (int r = 8; r <= 14; r++) m_sh[7][r] = '0;
            end else begin
                if (nb == 1) for (int r = 8; r <= 12; r++) m_sh[0][r] = m_live[r];
                m_sh[ob][13] = m_live[13];
                m_sh[ob][14] = m_live[14];
            end
            if (nb == 1) begin
                for (int r = 8; r <= 14; r++) m_live[r] = m_sh[1][r];
            end else if (nb == 7) begin
                for (int r = 8; r <= 14; r++) m_live[r] = '0;
            end else begin
                if (ob == 1) for (int r = 8; r <= 12; r++) m_live[r] = m_sh[0][r];
                m_live[13] = m_sh[nb][13];
                m_live[14] = m_sh[nb][14];
            end
        end
        m_mode = nm;
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] m, input int i);
        if (uses_live(m, i)) return m_live[i];
        return m_sh[mbank(m)][i];
    endfunction

    function automatic logic [31:0] model_status(input logic [4:0] m);
        int b = mbank(m);
        if (b == 0 || b == 6) return cur_status;
        return m_st[b];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (%s): actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic scan();
        check("R11 cur_mode", {27'd0, cur_mode}, {27'd0, m_mode});
        check("R9 nontrans", {31'd0, nontrans}, {31'd0, (m_mode[1:0] != 2'b00)});
        for (int i = 0; i < 16; i++) begin
            rd_mode = m_mode; rd_idx = 4'(i);
            #0.05;
            check("R6 live read", rd_data, model_read(m_mode, i));
        end
        for (int k = 0; k < 8; k++) begin
            rd_mode = 5'(probe_modes[k]); rd_idx = 4'd8;
            #0.05;
            check("R6 r8 other mode", rd_data, model_read(5'(probe_modes[k]), 8));
            rd_idx = 4'd13;
            #0.05;
            check("R6 r13 other mode", rd_data, model_read(5'(probe_modes[k]), 13));
            st_rd_mode = 5'(probe_modes[k]);
            #0.05;
            check("R8 status read", st_rd_data, model_status(5'(probe_modes[k])));
        end
    endtask

    task automatic cyc(input bit mc, input logic [4:0] mn,
                       input bit we, input logic [4:0] wm, input logic [3:0] wi, input logic [31:0] wd,
                       input bit se, input logic [4:0] sm, input logic [31:0] sd);
        mode_chg = mc; mode_new = mn;
        wr_en = we; wr_mode = wm; wr_idx = wi; wr_data = wd;
        st_wr_en = se; st_wr_mode = sm; st_wr_data = sd;
        @(posedge clk);
        if (se && mbank(sm) != 0 && mbank(sm) != 6) m_st[mbank(sm)] = sd;
        if (mc) model_switch(mn);
        else if (we) begin
            if (uses_live(wm, int'(wi))) m_live[wi] = wd;
            else m_sh[mbank(wm)][wi] = wd;
        end
        @(negedge clk);
        mode_chg = 1'b0; wr_en = 1'b0; st_wr_en = 1'b0;
        scan();
    endtask

    task automatic go(input logic [4:0] mn);
        cyc(1'b1, mn, 1'b0, '0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [4:0] wm, input int wi, input logic [31:0] wd);
        cyc(1'b0, '0, 1'b1, wm, 4'(wi), wd, 1'b0, '0, '0);
    endtask

    task automatic swr(input logic [4:0] sm, input logic [31:0] sd);
        cyc(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, sm, sd);
    endtask

    task automatic fill(input logic [4:0] m, input int lo, input int hi, input logic [31:0] base);
        for (int i = lo; i <= hi; i++) wr(m, i, base + 32'(i));
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        phase = "R10 reset state";
        scan();

        phase = "R6 fill supervisor live set";
        fill(5'd19, 0, 15, 32'h5000_0000);

        phase = "R3 supervisor to user";
        go(5'd16);
        fill(5'd16, 8, 14, 32'hA000_0000);

        phase = "R3 R4 user to fast-interrupt";
        go(5'd17);
        fill(5'd17, 8, 14, 32'hF000_0000);

        phase = "R4 fast-interrupt to interrupt";
        go(5'd18);
        wr(5'd18, 13, 32'h1111_1313);

        phase = "R2 R7 same bank change drops write";
        cyc(1'b1, 5'd2, 1'b1, 5'd2, 4'd9, 32'hDEAD_BEEF, 1'b0, '0, '0);

        phase = "R6 write other mode bank";
        wr(5'd17, 10, 32'hCAFE_0010);
        wr(5'd19, 14, 32'hCAFE_0014);
        wr(5'd17, 3, 32'hCAFE_0003);

        phase = "R4 re-enter fast-interrupt";
        go(5'd17);

        phase = "R5 enter dummy";
        go(5'd5);
        wr(5'd5, 9, 32'h0D0D_0009);
        wr(5'd5, 13, 32'h0D0D_0013);

        phase = "R5 leave dummy to user";
        go(5'd0);

        phase = "R1 abort undefined system codes";
        go(5'd23);
        wr(5'd23, 13, 32'hAB00_0013);
        go(5'd27);
        wr(5'd27, 14, 32'hDF00_0014);
        go(5'd31);
        wr(5'd31, 13, 32'h5900_0013);
        go(5'd16);

        phase = "R2 user codes share a bank";
        go(5'd0);
        go(5'd16);

        phase = "R1 unlisted codes are dummy";
        go(5'd4);
        go(5'd20);
        go(5'd8);
        go(5'd1);
        go(5'd30);
        go(5'd3);

        phase = "R8 saved status words";
        swr(5'd17, 32'h5757_0001);
        swr(5'd18, 32'h5757_0002);
        swr(5'd19, 32'h5757_0003);
        swr(5'd23, 32'h5757_0004);
        swr(5'd27, 32'h5757_0005);
        swr(5'd6,  32'h5757_0006);
        swr(5'd16, 32'h5757_0007);
        swr(5'd31, 32'h5757_0008);
        cur_status = 32'h1234_5678;
        scan();
        swr(5'd2, 32'h5757_0009);

        phase = "R11 R9 change with status write";
        cyc(1'b1, 5'd18, 1'b0, '0, '0, '0, 1'b1, 5'd3, 32'h5757_000A);
        go(5'd17);
        go(5'd16);

        phase = "R10 reset mid-run";
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        scan();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule